// File: doc/BRIEF.md
# Compare-Match Timer with Watchdog Channel

This peripheral keeps a free-running up-counter that advances once for every cycle in which a prescaled tick input is high. Several compare channels each hold a target value. When the counter steps onto a channel's target and that channel is enabled, a sticky flag is raised and the channel's interrupt line goes high until software clears it. Software reads and writes the block through a plain single-cycle register port: a write strobe with address and data, and read data that follows the address combinationally.

A read of the live count can come back mid-update, so the block also offers a snapshot. Writing a trigger bit copies the running count into a separate register that holds still for a later read. The highest-numbered channel also serves as a watchdog. When the watchdog is armed and that channel's interrupt enable is set, a match raises a one-cycle system reset request and disarms the watchdog. Software keeps the system alive by moving the channel's target further ahead before the count reaches it.

Top module: `match_timer_wdog`

## Requirements
- R1: After reset the count, every compare value, the interrupt enables, the watchdog arm bit, the status flags and the snapshot all read 0, and `irq` and `sys_rst_req` are low.
- R2: The count reads at address 0x00. It rises by one at each clock edge where `tick_en` is high and holds where it is low. Writes to 0x00 have no effect.
- R3: The count wraps from its all-ones value to 0, so after 2^CW ticks it returns to the value it started from.
- R4: Compare value i is read and written at address 0x08 + 4*i. The interrupt enable word sits at 0x24, with bit i for channel i. A register reads back the value last written to it, truncated to its width.
- R5: If channel i's enable bit is set when the count steps onto compare value i, status bit i and `irq[i]` go high from that same edge. A channel whose enable bit is clear never raises its flag.
- R6: Status reads at 0x2C with bit i for channel i. Writing a 1 to a bit clears it, and writing 0 leaves it unchanged. A match on the same edge wins over the clear.
- R7: A write to 0x30 with bit 0 set copies the count visible in that cycle into the snapshot at 0x34. A write with bit 0 clear does nothing. Address 0x30 reads as 0.
- R8: The watchdog channel is channel NCH-1 (5 by default). The arm bit is bit 0 at 0x28. If the arm bit and the channel's enable bit are both set when the count steps onto its compare value, `sys_rst_req` is high for the following cycle.
- R9: If the watchdog channel's enable bit is clear, a match raises no reset request, even when the watchdog is armed, and the arm bit stays set.
- R10: `sys_rst_req` lasts one cycle. The same edge clears the arm bit, so later matches raise no request until software arms the watchdog again.
- R11: Rewriting the watchdog compare value to a later count before it is reached postpones the reset request.
- R12: A compare value below the current count matches after the counter wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Prescaled count enable |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | NCH | Per-channel interrupt, equal to the status flags |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
On every cycle, the checker confirms that the count holds without a tick and wraps to zero after all-ones. It also confirms that a rising interrupt always had its enable set beforehand, and that every reset request followed an armed, enabled, ticking cycle, lasts one cycle and leaves the watchdog disarmed. The bench's scenarios are needed for the rest: keep-alive postponement, the masking of the reset by the channel enable, matches after rollover, the snapshot's timing, and the clear-versus-set ordering of the status register. The bench shows these by comparing every output against a behavioural model on each clock.

// File: rtl/mtw_pkg.sv
`timescale 1ns/1ps
package mtw_pkg;
  localparam int ADDR_W = 8;
  localparam int BUS_W  = 32;
  localparam logic [ADDR_W-1:0] A_COUNT    = 8'h00;
  localparam logic [ADDR_W-1:0] A_CMP_BASE = 8'h08;
  localparam logic [ADDR_W-1:0] A_IEN      = 8'h24;
  localparam logic [ADDR_W-1:0] A_ARM      = 8'h28;
  localparam logic [ADDR_W-1:0] A_STAT     = 8'h2C;
  localparam logic [ADDR_W-1:0] A_TRIG     = 8'h30;
  localparam logic [ADDR_W-1:0] A_SNAP     = 8'h34;
endpackage

// File: rtl/mtw_counter.sv
`timescale 1ns/1ps
module mtw_counter #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          snap_req,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_nxt,
  output logic [CW-1:0] snap_q
);
  // next count feeds the compare channels so a match lands on the same edge
  assign cnt_nxt = tick_en ? cnt_q + CW'(1) : cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      snap_q <= '0;
    end else begin
      cnt_q <= cnt_nxt;
      if (snap_req) snap_q <= cnt_q;
    end
  end
endmodule

// File: rtl/mtw_channel.sv
`timescale 1ns/1ps
module mtw_channel #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic [CW-1:0] cnt_nxt,
  input  logic          cmp_we,
  input  logic [CW-1:0] cmp_wdata,
  input  logic          irq_en,
  input  logic          stat_clr,
  output logic [CW-1:0] cmp_q,
  output logic          hit,
  output logic          stat_q
);
  assign hit = tick_en && (cnt_nxt == cmp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      stat_q <= 1'b0;
    end else begin
      if (cmp_we) cmp_q <= cmp_wdata;
      if (hit && irq_en) stat_q <= 1'b1;
      else if (stat_clr) stat_q <= 1'b0;
    end
  end
endmodule

// File: rtl/mtw_wdog.sv
`timescale 1ns/1ps
module mtw_wdog (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_we,
  input  logic arm_wbit,
  input  logic ch_en,
  input  logic hit,
  output logic wd_en_q,
  output logic rst_req_q
);
  logic fire;
  assign fire = hit && ch_en && wd_en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_en_q   <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      rst_req_q <= fire;
      if (fire) wd_en_q <= 1'b0;
      else if (arm_we) wd_en_q <= arm_wbit;
    end
  end
endmodule

// File: rtl/match_timer_wdog.sv
`timescale 1ns/1ps
module match_timer_wdog
  import mtw_pkg::*;
#(
  parameter int NCH    = 6,
  parameter int CW     = 32,
  parameter int WD_IDX = NCH - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic [NCH-1:0]    irq,
  output logic              sys_rst_req
);
  logic [CW-1:0]  cnt_q, cnt_nxt, snap_q;
  logic [CW-1:0]  cmp [NCH];
  logic [NCH-1:0] hit, stat, ien_q;
  logic           wd_en;
  logic           wr_ien, wr_arm, wr_stat, snap_req;

  assign wr_ien   = bus_wr && (bus_addr == A_IEN);
  assign wr_arm   = bus_wr && (bus_addr == A_ARM);
  assign wr_stat  = bus_wr && (bus_addr == A_STAT);
  assign snap_req = bus_wr && (bus_addr == A_TRIG) && bus_wdata[0];

  function automatic logic [BUS_W-1:0] zext(input logic [CW-1:0] v);
    logic [BUS_W-1:0] r;
    r = '0;
    r[CW-1:0] = v;
    return r;
  endfunction

  mtw_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .snap_req(snap_req),
    .cnt_q(cnt_q), .cnt_nxt(cnt_nxt), .snap_q(snap_q)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic cmp_we;
    assign cmp_we = bus_wr && (bus_addr == ADDR_W'(int'(A_CMP_BASE) + 4*g));
    mtw_channel #(.CW(CW)) u_ch (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_nxt(cnt_nxt),
      .cmp_we(cmp_we), .cmp_wdata(bus_wdata[CW-1:0]), .irq_en(ien_q[g]),
      .stat_clr(wr_stat && bus_wdata[g]),
      .cmp_q(cmp[g]), .hit(hit[g]), .stat_q(stat[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ien_q <= '0;
    else if (wr_ien) ien_q <= bus_wdata[NCH-1:0];
  end

  mtw_wdog u_wd (
    .clk(clk), .rst_n(rst_n), .arm_we(wr_arm), .arm_wbit(bus_wdata[0]),
    .ch_en(ien_q[WD_IDX]), .hit(hit[WD_IDX]),
    .wd_en_q(wd_en), .rst_req_q(sys_rst_req)
  );

  assign irq = stat;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_COUNT: bus_rdata = zext(cnt_q);
      A_IEN:   bus_rdata[NCH-1:0] = ien_q;
      A_ARM:   bus_rdata[0] = wd_en;
      A_STAT:  bus_rdata[NCH-1:0] = stat;
      A_SNAP:  bus_rdata = zext(snap_q);
      default: bus_rdata = '0;
    endcase
    for (int i = 0; i < NCH; i++) begin
      if (bus_addr == ADDR_W'(int'(A_CMP_BASE) + 4*i)) bus_rdata = zext(cmp[i]);
    end
  end
endmodule

// File: rtl/mtw_checker.sv
`timescale 1ns/1ps
module mtw_checker #(
  parameter int NCH    = 6,
  parameter int CW     = 32,
  parameter int WD_IDX = NCH - 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           tick_en,
  input logic [NCH-1:0] irq,
  input logic [NCH-1:0] ien,
  input logic           sys_rst_req,
  input logic           wd_en,
  input logic [CW-1:0]  cnt
);
  a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> cnt == $past(cnt));

  a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && cnt == {CW{1'b1}}) |=> cnt == '0);

  a_r5_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (irq & ~$past(irq) & ~$past(ien)) == '0);

  a_r8_reset_cause: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> ($past(wd_en) && $past(ien[WD_IDX]) && $past(tick_en)));

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |=> !sys_rst_req);

  a_r10_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> !wd_en);
endmodule

bind match_timer_wdog mtw_checker #(.NCH(NCH), .CW(CW), .WD_IDX(WD_IDX)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .irq(irq), .ien(ien_q),
  .sys_rst_req(sys_rst_req), .wd_en(wd_en), .cnt(cnt_q)
);

// File: tb/match_timer_wdog_test.sv
`timescale 1ns/1ps
module match_timer_wdog_test;
  localparam int NCH = 6;
  localparam int CW  = 10;
  localparam int WD  = NCH - 1;

  logic clk = 0, rst_n = 0, tick_en = 0, bus_wr = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [NCH-1:0] irq;
  logic sys_rst_req;

  match_timer_wdog #(.NCH(NCH), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .sys_rst_req(sys_rst_req)
  );

  always #10 clk = ~clk;

  int errors = 0, checks = 0, pulses = 0, tmode = 0;
  bit done = 0;

  // behavioural reference
  logic [CW-1:0] m_cnt, m_lat, nxt;
  logic [CW-1:0] m_cmp [NCH];
  logic [NCH-1:0] m_ien, m_stat, h, ns;
  logic m_wden, m_rst, fire;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_lat = 0; m_ien = 0; m_stat = 0; m_wden = 0; m_rst = 0;
      for (int i = 0; i < NCH; i++) m_cmp[i] = 0;
    end else begin
      nxt = tick_en ? m_cnt + 1'b1 : m_cnt;
      for (int i = 0; i < NCH; i++) h[i] = tick_en && (nxt == m_cmp[i]);
      fire = h[WD] && m_wden && m_ien[WD];
      ns = m_stat;
      if (bus_wr && bus_addr == 8'h2C) ns = ns & ~bus_wdata[NCH-1:0];
      ns = ns | (h & m_ien);
      if (bus_wr) begin
        for (int i = 0; i < NCH; i++)
          if (bus_addr == 8'(8 + 4*i)) m_cmp[i] = bus_wdata[CW-1:0];
        if (bus_addr == 8'h30 && bus_wdata[0]) m_lat = m_cnt;
      end
      if (fire) m_wden = 0;
      else if (bus_wr && bus_addr == 8'h28) m_wden = bus_wdata[0];
      if (bus_wr && bus_addr == 8'h24) m_ien = bus_wdata[NCH-1:0];
      m_stat = ns; m_rst = fire; m_cnt = nxt;
    end
  end

  function automatic logic [31:0] mread(logic [7:0] a);
    logic [31:0] r = 0;
    case (a)
      8'h00: r[CW-1:0] = m_cnt;
      8'h24: r[NCH-1:0] = m_ien;
      8'h28: r[0] = m_wden;
      8'h2C: r[NCH-1:0] = m_stat;
      8'h34: r[CW-1:0] = m_lat;
      default: r = 0;
    endcase
    for (int i = 0; i < NCH; i++) if (a == 8'(8 + 4*i)) r[CW-1:0] = m_cmp[i];
    return r;
  endfunction

  function automatic string tag_of(logic [7:0] a);
    if (a == 8'h00) return "R2";
    if (a == 8'h2C) return "R6";
    if (a == 8'h28) return "R10";
    if (a == 8'h34 || a == 8'h30) return "R7";
    return "R4";
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(posedge clk) begin
    #5;
    if (rst_n && !done) begin
      check("R5", 32'(irq), 32'(m_stat));
      check("R8", 32'(sys_rst_req), 32'(m_rst));
      check(tag_of(bus_addr), bus_rdata, mread(bus_addr));
      if (sys_rst_req) pulses++;
    end
  end

  task automatic tk();
    tick_en = (tmode == 0) ? 1'b1 : (tmode == 1) ? 1'b0 : 1'($urandom_range(0, 1));
  endtask
  task automatic idle(int n);
    repeat (n) begin @(negedge clk); bus_wr = 0; tk(); end
  endtask
  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d; tk();
    @(negedge clk); bus_wr = 0; tk();
  endtask
  task automatic rd(logic [7:0] a, output logic [31:0] v);
    @(negedge clk); bus_wr = 0; bus_addr = a; tk(); #1; v = bus_rdata;
  endtask
  task automatic chk_rd(logic [7:0] a, logic [31:0] exp, string tag);
    logic [31:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] c0, c1;
    int p0;
    tmode = 1;
    idle(3);
    @(negedge clk); rst_n = 1;
    // R1: reset state
    chk_rd(8'h00, 0, "R1"); chk_rd(8'h2C, 0, "R1"); chk_rd(8'h28, 0, "R1");
    chk_rd(8'h34, 0, "R1"); chk_rd(8'h1C, 0, "R1");
    check("R1", {31'b0, sys_rst_req}, 0); check("R1", 32'(irq), 0);
    // R2: hold without tick, write to count ignored
    tmode = 0; idle(17); tmode = 1;
    rd(8'h00, c0); idle(8); chk_rd(8'h00, c0, "R2");
    check("R2", c0, 17);
    wr(8'h00, 32'h155); chk_rd(8'h00, c0, "R2");
    // R4: compare readback
    for (int i = 0; i < NCH; i++) wr(8'(8 + 4*i), 32'hFF000 + 32'(100 + 7*i));
    for (int i = 0; i < NCH; i++) chk_rd(8'(8 + 4*i), 32'(100 + 7*i), "R4");
    // R5: ch0 enabled at 40, ch1 disabled at 45
    wr(8'h08, 40); wr(8'h0C, 45); wr(8'h24, 32'h1);
    chk_rd(8'h24, 1, "R4");
    tmode = 0; idle(40); tmode = 1;
    chk_rd(8'h2C, 1, "R5"); check("R5", 32'(irq), 1);
    // R6: clear with 0 leaves, clear with 1 removes
    wr(8'h2C, 0); chk_rd(8'h2C, 1, "R6");
    wr(8'h2C, 1); chk_rd(8'h2C, 0, "R6");
    // R7: snapshot
    rd(8'h00, c0); wr(8'h30, 1); chk_rd(8'h34, c0, "R7");
    tmode = 0; idle(9); tmode = 1; wr(8'h30, 0); chk_rd(8'h34, c0, "R7");
    chk_rd(8'h30, 0, "R7");
    // R3: full wrap returns to the same count
    rd(8'h00, c0); tmode = 0; idle(1 << CW); tmode = 1; chk_rd(8'h00, c0, "R3");
    // R11 and R8: keep-alive then expiry
    rd(8'h00, c0);
    wr(8'h1C, (c0 + 40) & 32'h3FF); wr(8'h24, 32'h21); wr(8'h28, 1);
    chk_rd(8'h28, 1, "R8");
    p0 = pulses; tmode = 0;
    for (int k = 0; k < 4; k++) begin
      idle(25);
      wr(8'h1C, (32'(m_cnt) + 40) & 32'h3FF);
    end
    check("R11", 32'(pulses), 32'(p0));
    idle(60);
    check("R8", 32'(pulses), 32'(p0 + 1));
    // R10: disarmed, no second pulse after another wrap
    chk_rd(8'h28, 0, "R10");
    idle(1100);
    check("R10", 32'(pulses), 32'(p0 + 1));
    // R9: channel enable clear masks the reset
    wr(8'h24, 32'h1); wr(8'h28, 1);
    wr(8'h1C, (32'(m_cnt) + 20) & 32'h3FF);
    idle(40);
    check("R9", 32'(pulses), 32'(p0 + 1));
    chk_rd(8'h28, 1, "R9");
    // R12: compare below count matches after rollover, irregular ticks
    wr(8'h2C, 32'h3F);
    wr(8'h08, (32'(m_cnt) - 5) & 32'h3FF);
    chk_rd(8'h2C, 0, "R12");
    tmode = 2; idle(2600); tmode = 1;
    rd(8'h2C, c1); check("R12", c1 & 1, 1);
    idle(2);
    finish_run();
  end
endmodule